// File: doc/BRIEF.md
# Dual-Clock FIFO with Encoded Occupancy Flags

This block is a first-in first-out buffer with separate write and read clocks. Each port has an active-low enable. Three flag pins together report the fill level as one of six states. The write clock owns the pins that describe fullness. The read clock owns the pins that describe emptiness. The write and read pointers cross between the two domains as Gray codes through two-flop synchronizers.

The almost-empty and almost-full threshold is one shared distance, called the offset. Software sets it through the write data bus while the active-low master reset is held. The offset is measured from the empty end for almost-empty and from the full end for almost-full. While reset is still held, a read returns the offset on the read data bus so that software can confirm it. If no offset is written during a reset, the default value is used. A normal transfer needs no handshake: write or read with the enable low, and watch the flags.

Top module: `xclk_fifo_flags`

## Requirements
- R1: After master reset is released (both clocks ran while `mreset_n` was low), {`flag_ef`,`flag_pafe`,`flag_hf`} reads 001 and `rd_data` reads 0.
- R2: A write occurs on a `wr_clk` rising edge with `wr_en_n` low. A read occurs on a `rd_clk` rising edge with `rd_en_n` low, and `rd_data` takes the word on that edge. Words leave in the order they were accepted.
- R3: A write attempted while the FIFO is full is dropped. It overwrites nothing, and the flags stay at Full.
- R4: A read attempted while the FIFO is empty is dropped, and `rd_data` keeps the last word that was validly read.
- R5: With n stored words, DEPTH entries and offset P, once both clocks have run three edges with no transfer, the code {`flag_ef`,`flag_pafe`,`flag_hf`} is:
  - 001 when n = 0
  - 000 when n = DEPTH
  - otherwise 101 when n ≤ P
  - otherwise 100 when DEPTH − n ≤ P
  - otherwise 110 when n ≥ DEPTH/2
  - otherwise 111
  
  The codes 010 and 011 never appear.
- R6: If no offset is written during a reset, P is DEFAULT_OFFS (16 by default), and a read during that reset returns 16.
- R7: While `mreset_n` is low, a `wr_clk` edge with `wr_en_n` low loads P from `wr_data[ADDR_W-2:0]` and ignores the upper data bits. A `rd_clk` edge with `rd_en_n` low during the same reset places P, zero-extended, on `rd_data`.
- R8: A write does not change the Empty or Almost-empty state until later `rd_clk` edges occur. A read does not change the Full, Almost-full or Half state until later `wr_clk` edges occur.
- R9: A read from one stored word shows 001 on the edge of that read. A write into DEPTH−1 stored words shows 000 on the edge of that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mreset_n | input | 1 | Master reset, active low, sampled by both clocks |
| wr_en_n | input | 1 | Write enable, active low (offset load during reset) |
| rd_en_n | input | 1 | Read enable, active low (offset readback during reset) |
| wr_data | input | DATA_W | Write word; low ADDR_W-1 bits carry the offset during reset |
| rd_data | output | DATA_W | Last word read, offset readback, or zero |
| flag_ef | output | 1 | Low when empty or full |
| flag_pafe | output | 1 | Low when almost empty or almost full |
| flag_hf | output | 1 | Low when at least half full |

## Verification
The assertions check, on every clock, the invariants of a single domain:
- a full write or an empty read leaves its pointer unchanged;
- the write pointer's Gray code changes by at most one bit per edge;
- occupancy never exceeds the depth;
- Empty implies Almost-empty, and Full implies both Almost-full and Half;
- the pins never show an illegal code.

Several behaviours can only be shown by the bench's scenarios, because each compares the two clocks or the data:
- the full six-state map across every fill level for several offsets;
- data order;
- offset load and readback;
- the flags holding their stale state until the owning clock runs.

// File: rtl/xfifo_pkg.sv
`timescale 1ns/1ps
package xfifo_pkg;
  // Source selected for the read data output register path
  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_RAM  = 2'd1,
    SRC_PROG = 2'd2
  } rd_src_e;
endpackage

// File: rtl/xfifo_ram.sv
`timescale 1ns/1ps
// Simple dual-port storage, one write clock and one registered read clock.
module xfifo_ram #(
  parameter int DW = 18,
  parameter int AW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // q holds its value when no read is accepted (empty reads keep last word)
  always_ff @(posedge rclk) begin
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/xfifo_gray_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a Gray-coded pointer, converted back to binary.
module xfifo_gray_sync #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= gray_in;
      s2 <= s1;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_g2b
    assign bin_out[i] = ^s2[W-1:i];
  end
endmodule

// File: rtl/xfifo_wr_ctrl.sv
`timescale 1ns/1ps
// Write domain: pointer, fullness flags and the offset register.
module xfifo_wr_ctrl #(
  parameter int AW           = 9,
  parameter int PW           = 8,
  parameter int DEFAULT_OFFS = 16
) (
  input  logic          wclk,
  input  logic          mrst_n,
  input  logic          wr_en_n,
  input  logic [PW-1:0] prog_in,
  input  logic [AW:0]   rd_bin_s,
  output logic [AW-1:0] waddr,
  output logic          we,
  output logic [AW:0]   wr_gray,
  output logic [AW-1:0] offs,
  output logic          full_q,
  output logic          af_q,
  output logic          half_q
);
  localparam int PTR_W = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] HALF_P  = PTR_W'(DEPTH / 2);

  logic [PTR_W-1:0] wr_bin, wr_bin_nxt, cnt_nxt, free_nxt;
  logic             in_rst_q = 1'b0;

  assign we         = mrst_n & ~wr_en_n & ~full_q;
  assign waddr      = wr_bin[AW-1:0];
  assign wr_bin_nxt = wr_bin + PTR_W'(we);
  assign cnt_nxt    = wr_bin_nxt - rd_bin_s;
  assign free_nxt   = DEPTH_P - cnt_nxt;

  always_ff @(posedge wclk) begin
    if (!mrst_n) begin
      wr_bin  <= '0;
      wr_gray <= '0;
      full_q  <= 1'b0;
      af_q    <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      wr_bin  <= wr_bin_nxt;
      wr_gray <= wr_bin_nxt ^ (wr_bin_nxt >> 1);
      full_q  <= (cnt_nxt == DEPTH_P);
      af_q    <= (free_nxt <= {1'b0, offs});
      half_q  <= (cnt_nxt >= HALF_P);
    end
  end

  // Offset: default on reset entry, bus load on any enabled edge in reset
  always_ff @(posedge wclk) begin
    in_rst_q <= ~mrst_n;
    if (!mrst_n) begin
      if (!wr_en_n)       offs <= AW'(prog_in);
      else if (!in_rst_q) offs <= AW'(DEFAULT_OFFS);
    end
  end

  assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!mrst_n)
    full_q && !wr_en_n |=> $stable(wr_bin));
  assert_wr_occupancy_R3: assert property (@(posedge wclk) disable iff (!mrst_n)
    (wr_bin - rd_bin_s) <= DEPTH_P);
  assert_gray_step_R2: assert property (@(posedge wclk) disable iff (!mrst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);
  assert_full_nesting_R5: assert property (@(posedge wclk) disable iff (!mrst_n)
    full_q |-> (af_q && half_q));
endmodule

// File: rtl/xfifo_rd_ctrl.sv
`timescale 1ns/1ps
// Read domain: pointer, emptiness flags and output source selection.
module xfifo_rd_ctrl
  import xfifo_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          rd_en_n,
  input  logic [AW:0]   wr_bin_s,
  input  logic [AW-1:0] offs,
  output logic [AW-1:0] raddr,
  output logic          re,
  output logic [AW:0]   rd_gray,
  output logic          empty_q,
  output logic          ae_q,
  output rd_src_e       src_q,
  output logic [AW-1:0] offs_cap
);
  localparam int PTR_W = AW + 1;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << AW);

  logic [PTR_W-1:0] rd_bin, rd_bin_nxt, cnt_nxt;
  logic             in_rst_q = 1'b0;

  assign re         = mrst_n & ~rd_en_n & ~empty_q;
  assign raddr      = rd_bin[AW-1:0];
  assign rd_bin_nxt = rd_bin + PTR_W'(re);
  assign cnt_nxt    = wr_bin_s - rd_bin_nxt;

  always_ff @(posedge rclk) begin
    if (!mrst_n) begin
      rd_bin  <= '0;
      rd_gray <= '0;
      empty_q <= 1'b1;
      ae_q    <= 1'b1;
    end else begin
      rd_bin  <= rd_bin_nxt;
      rd_gray <= rd_bin_nxt ^ (rd_bin_nxt >> 1);
      empty_q <= (cnt_nxt == '0);
      ae_q    <= (cnt_nxt <= {1'b0, offs});
    end
  end

  // Output source: zero on reset entry/exit, offset on readback, RAM on reads
  always_ff @(posedge rclk) begin
    in_rst_q <= ~mrst_n;
    if (!mrst_n) begin
      if (!rd_en_n) begin
        src_q    <= SRC_PROG;
        offs_cap <= offs;
      end else if (!in_rst_q) begin
        src_q <= SRC_ZERO;
      end
    end else if (in_rst_q) begin
      src_q <= SRC_ZERO;
    end else if (re) begin
      src_q <= SRC_RAM;
    end
  end

  assert_no_underflow_R4: assert property (@(posedge rclk) disable iff (!mrst_n)
    empty_q && !rd_en_n |=> $stable(rd_bin));
  assert_rd_occupancy_R2: assert property (@(posedge rclk) disable iff (!mrst_n)
    (wr_bin_s - rd_bin) <= DEPTH_P);
  assert_empty_nesting_R5: assert property (@(posedge rclk) disable iff (!mrst_n)
    empty_q |-> ae_q);
endmodule

// File: rtl/xclk_fifo_flags.sv
`timescale 1ns/1ps
// Dual-clock FIFO with three encoded flag pins and a reset-time offset register.
module xclk_fifo_flags
  import xfifo_pkg::*;
#(
  parameter int DATA_W       = 18,
  parameter int ADDR_W       = 9,
  parameter int DEFAULT_OFFS = 16
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              mreset_n,
  input  logic              wr_en_n,
  input  logic              rd_en_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              flag_ef,
  output logic              flag_pafe,
  output logic              flag_hf
);
  localparam int PTR_W  = ADDR_W + 1;
  localparam int PROG_W = ADDR_W - 1;

  logic [ADDR_W-1:0] waddr, raddr, offs, offs_cap;
  logic              we, re;
  logic [PTR_W-1:0]  wr_gray, rd_gray, wr_bin_s, rd_bin_s;
  logic              full_q, af_q, half_q, empty_q, ae_q;
  logic [DATA_W-1:0] ram_q;
  rd_src_e           src_q;

  xfifo_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .re(re), .raddr(raddr), .q(ram_q)
  );

  xfifo_wr_ctrl #(.AW(ADDR_W), .PW(PROG_W), .DEFAULT_OFFS(DEFAULT_OFFS)) u_wr (
    .wclk(wr_clk), .mrst_n(mreset_n), .wr_en_n(wr_en_n),
    .prog_in(wr_data[PROG_W-1:0]), .rd_bin_s(rd_bin_s),
    .waddr(waddr), .we(we), .wr_gray(wr_gray), .offs(offs),
    .full_q(full_q), .af_q(af_q), .half_q(half_q)
  );

  xfifo_rd_ctrl #(.AW(ADDR_W)) u_rd (
    .rclk(rd_clk), .mrst_n(mreset_n), .rd_en_n(rd_en_n),
    .wr_bin_s(wr_bin_s), .offs(offs),
    .raddr(raddr), .re(re), .rd_gray(rd_gray),
    .empty_q(empty_q), .ae_q(ae_q), .src_q(src_q), .offs_cap(offs_cap)
  );

  xfifo_gray_sync #(.W(PTR_W)) u_sync_rd2wr (
    .clk(wr_clk), .rst_n(mreset_n), .gray_in(rd_gray), .bin_out(rd_bin_s)
  );

  xfifo_gray_sync #(.W(PTR_W)) u_sync_wr2rd (
    .clk(rd_clk), .rst_n(mreset_n), .gray_in(wr_gray), .bin_out(wr_bin_s)
  );

  always_comb begin
    unique case (src_q)
      SRC_RAM:  rd_data = ram_q;
      SRC_PROG: rd_data = DATA_W'(offs_cap);
      default:  rd_data = '0;
    endcase
  end

  assign flag_ef   = ~(empty_q | full_q);
  assign flag_pafe = ~(ae_q | af_q);
  assign flag_hf   = ~half_q;

  // Codes 010 and 011 are illegal: Empty/Full always imply an almost state
  assert_legal_code_R5: assert property (@(posedge rd_clk) disable iff (!mreset_n)
    !(!flag_ef && flag_pafe));
endmodule

// File: tb/tb_xclk_fifo_flags.sv
`timescale 1ns/1ps
module tb_xclk_fifo_flags;
  localparam int AW = 6;
  localparam int D  = 1 << AW;
  localparam int DW = 18;

  logic          wclk = 1'b0, rclk = 1'b0;
  logic          mreset_n = 1'b0, wr_en_n = 1'b1, rd_en_n = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          flag_ef, flag_pafe, flag_hf;

  int vectors = 0, errors = 0;
  int n = 0, wi = 0, ri = 0, seed = 0, p = 16;
  logic [DW-1:0] last = '0;
  bit done = 1'b0;

  xclk_fifo_flags #(.DATA_W(DW), .ADDR_W(AW), .DEFAULT_OFFS(16)) dut (
    .wr_clk(wclk), .rd_clk(rclk), .mreset_n(mreset_n),
    .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .wr_data(wr_data),
    .rd_data(rd_data), .flag_ef(flag_ef), .flag_pafe(flag_pafe), .flag_hf(flag_hf)
  );

  function automatic logic [DW-1:0] pat(int i, int s);
    return DW'(i * 4099 + s * 13107 + 5);
  endfunction

  function automatic logic [2:0] expf(int occ, int po);
    if (occ == 0)           return 3'b001;
    else if (occ == D)      return 3'b000;
    else if (occ <= po)     return 3'b101;
    else if (D - occ <= po) return 3'b100;
    else if (occ >= D / 2)  return 3'b110;
    else                    return 3'b111;
  endfunction

  function automatic logic [2:0] pins();
    return {flag_ef, flag_pafe, flag_hf};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (n=%0d)", req, what, act, exp, n);
    end
  endtask

  // 125 MHz pulses; inputs change and outputs are sampled while clocks are low
  task automatic wtick();
    wclk = 1'b1; #4; wclk = 1'b0; #4;
  endtask
  task automatic rtick();
    rclk = 1'b1; #4; rclk = 1'b0; #4;
  endtask
  task automatic settle();
    repeat (3) rtick();
    repeat (3) wtick();
  endtask

  task automatic write_word();
    wr_data = pat(wi, seed);
    wr_en_n = 1'b0;
    wtick();
    wr_en_n = 1'b1;
    if (n < D) begin n++; wi++; end
  endtask

  task automatic read_word(string req);
    rd_en_n = 1'b0;
    rtick();
    rd_en_n = 1'b1;
    if (n > 0) begin
      chk(req, "read data", 32'(rd_data), 32'(pat(ri, seed)));
      last = pat(ri, seed);
      ri++; n--;
    end else begin
      chk(req, "held word", 32'(rd_data), 32'(last));
    end
  endtask

  task automatic do_reset(bit prog, int pv, int s);
    mreset_n = 1'b0; wr_en_n = 1'b1; rd_en_n = 1'b1;
    wtick(); rtick();
    if (prog) begin
      // R7: upper bits set to show only the low ADDR_W-1 bits are taken
      wr_data = DW'(32'h2A020 | pv);
      wr_en_n = 1'b0;
      wtick();
      wr_en_n = 1'b1;
      p = pv;
    end else begin
      p = 16;
    end
    wtick(); rtick();
    rd_en_n = 1'b0;
    rtick();
    rd_en_n = 1'b1;
    if (prog) chk("R7", "offset readback", 32'(rd_data), 32'(pv));
    else      chk("R6", "default readback", 32'(rd_data), 32'd16);
    mreset_n = 1'b1;
    wtick(); wtick(); rtick(); rtick();
    chk("R1", "flags after reset", 32'(pins()), 32'b001);
    chk("R1", "data after reset", 32'(rd_data), 32'd0);
    n = 0; wi = 0; ri = 0; seed = s; last = '0;
  endtask

  task automatic sweep(bit prog, int pv, int s);
    do_reset(prog, pv, s);
    for (int k = 1; k <= D; k++) begin
      write_word();
      if (n == D) chk("R9", "full on that write", 32'(pins()), 32'b000);
      settle();
      if (prog) chk("R5", "fill flags", 32'(pins()), 32'(expf(n, p)));
      else      chk("R6", "fill flags default", 32'(pins()), 32'(expf(n, p)));
    end
    write_word();                 // dropped: FIFO is full
    settle();
    chk("R3", "flags after full write", 32'(pins()), 32'b000);
    for (int k = 1; k <= D; k++) begin
      read_word("R2");
      if (n == 0) chk("R9", "empty on that read", 32'(pins()), 32'b001);
      settle();
      chk("R5", "drain flags", 32'(pins()), 32'(expf(n, p)));
    end
    for (int k = 0; k < 2; k++) begin
      read_word("R4");
      settle();
      chk("R4", "flags on empty read", 32'(pins()), 32'b001);
    end
  endtask

  initial begin
    sweep(1'b0, 0, 1);
    sweep(1'b1, 5, 2);
    sweep(1'b1, 31, 3);
    sweep(1'b1, 0, 4);

    // R8: read clock halted, writes must not clear the emptiness states
    do_reset(1'b0, 0, 7);
    repeat (3) write_word();
    repeat (3) wtick();
    chk("R8", "empty held without rd_clk", 32'(pins()), 32'b001);
    repeat (3) rtick();
    chk("R8", "after rd_clk edges", 32'(pins()), 32'(expf(3, 16)));

    // R8: write clock halted, a read must not clear the fullness states
    do_reset(1'b0, 0, 9);
    for (int k = 0; k < D; k++) write_word();
    settle();
    read_word("R2");
    repeat (3) rtick();
    chk("R8", "full held without wr_clk", 32'(pins()), 32'b000);
    repeat (3) wtick();
    chk("R8", "after wr_clk edges", 32'(pins()), 32'(expf(D - 1, 16)));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule